// File: doc/BRIEF.md
# Frequency-Domain Correlation Sweep Sequencer

This block drives the multiply stage of a block-correlating acquisition engine for a spread-spectrum navigation receiver. One forward transform of a long capture (N1 samples per code period times N2 coherently summed periods) sits in an external memory. The block treats that transform as N2 columns of N1 points each. It also reads a table of precomputed replica spectra, one N1-point spectrum per satellite. For every satellite, every coarse frequency step and every column, it streams the pointwise product of the column with the conjugated replica spectrum to an external inverse-transform engine. Each result vector is tagged so that the correlation surface can be reassembled afterwards.

Each column gives one fine Doppler bin, and the fine bins are 1/N2 kHz apart. Coarse 1 kHz steps need no new carrier mixing: they come from rotating the replica read address by the step index. A single forward transform therefore serves the whole search over satellites, code phase and Doppler. The number of integrated periods is picked per sweep (1, 2 or 4). Both memories are read with a shared read enable and give their data one cycle after the address. The result leaves on a valid/ready stream.

Top module: `fdc_sweep_seq`

## Requirements
- R1: After reset, busy_o, mem_rd_o and out_valid_o are low.
- R2: A start_i pulse while busy_o is low begins one sweep. A start_i pulse while busy_o is high has no effect: the sweep in progress delivers exactly its own element count and no more.
- R3: n2_sel_i is sampled only at an accepted start. Value 0 selects 1 column, value 1 selects 2 columns, and values 2 and 3 select 4 columns. A change of n2_sel_i during a sweep has no effect on that sweep.
- R4: The element for row i, column j is read from long-transform address i*N2 + j.
- R5: For satellite p and coarse step s, the replica is read at address p*N1 + ((i - s) mod N1).
- R6: Each output equals (a+jb)(c-jd), with a+jb the transform sample and c+jd the replica sample: out_re_o = ac+bd and out_im_o = bc-ad, at full signed width 2W+1.
- R7: Elements leave in this nesting, from outermost to innermost: satellite 0..NUM_SAT-1, coarse step -SHIFT_MAX..+SHIFT_MAX, column 0..N2-1, row 0..N1-1. Each element carries its satellite, step and column tags.
- R8: out_first_o is high exactly on row 0 and out_last_o exactly on row N1-1. The element that follows an accepted last element is a first element.
- R9: While out_valid_o is high and out_ready_i is low, all output fields hold their values. No element is lost or duplicated under backpressure.
- R10: busy_o rises in the cycle after an accepted start and falls in the cycle after the final element is accepted. No memory read is issued while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one sweep |
| n2_sel_i | input | 2 | Number of integrated periods: 0 gives 1, 1 gives 2, 2 or 3 give 4 |
| busy_o | output | 1 | Sweep in progress or results still in flight |
| mem_rd_o | output | 1 | Read enable for both memories; their data updates one cycle later |
| fft_addr_o | output | log2(N1)+2 | Long-transform read address |
| fft_re_i | input | W | Long-transform sample, real part |
| fft_im_i | input | W | Long-transform sample, imaginary part |
| rep_addr_o | output | log2(NUM_SAT)+log2(N1) | Replica table read address |
| rep_re_i | input | W | Replica sample, real part |
| rep_im_i | input | W | Replica sample, imaginary part |
| out_valid_o | output | 1 | Output element valid |
| out_ready_i | input | 1 | Downstream accepts the element |
| out_re_o | output | 2W+1 | Product, real part |
| out_im_o | output | 2W+1 | Product, imaginary part |
| out_sat_o | output | log2(NUM_SAT) | Satellite tag |
| out_shift_o | output | log2(SHIFT_MAX+1)+1 | Coarse step tag, signed |
| out_col_o | output | 2 | Column (fine bin) tag |
| out_first_o | output | 1 | First row of a vector |
| out_last_o | output | 1 | Last row of a vector |

## Verification
Two things can land on the same clock edge: output backpressure and the freeze of the address generator and memory read. The read enable and the pipeline registers share one advance signal, so a stall also stops the memories from loading. The bench drops out_ready_i at random while elements are moving. After every stall it checks that the held element is unchanged, and then that the next accepted element is still the right product at the right position in the sweep. It also sends a second start and a new column count in the middle of a sweep and confirms that the element count and the tags stay those of the first start.

// File: rtl/fdc_pkg.sv
`timescale 1ns/1ps
package fdc_pkg;
  localparam int N2_MAX = 4;
  localparam int COL_W  = 2;

  typedef enum logic [1:0] {
    N2_ONE  = 2'd0,
    N2_TWO  = 2'd1,
    N2_FOUR = 2'd2
  } n2_mode_e;

  // log2 of column count for a select code
  function automatic logic [1:0] n2_log(input logic [1:0] sel);
    case (sel)
      N2_ONE:  n2_log = 2'd0;
      N2_TWO:  n2_log = 2'd1;
      default: n2_log = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/fdc_addr_gen.sv
`timescale 1ns/1ps
module fdc_addr_gen
  import fdc_pkg::*;
#(
  parameter int N1        = 2048,
  parameter int NUM_SAT   = 24,
  parameter int SHIFT_MAX = 10,
  localparam int ROW_W    = $clog2(N1),
  localparam int SAT_W    = $clog2(NUM_SAT),
  localparam int SH_W     = $clog2(SHIFT_MAX + 1) + 1,
  localparam int FFT_AW   = ROW_W + COL_W,
  localparam int REP_AW   = SAT_W + ROW_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_go_i,
  input  logic [1:0]              n2_sel_i,
  input  logic                    adv_i,
  output logic                    running_o,
  output logic                    rd_en_o,
  output logic [FFT_AW-1:0]       fft_addr_o,
  output logic [REP_AW-1:0]       rep_addr_o,
  output logic [SAT_W-1:0]        sat_o,
  output logic signed [SH_W-1:0]  shift_o,
  output logic [COL_W-1:0]        col_o,
  output logic                    first_o,
  output logic                    last_o
);
  logic [ROW_W-1:0]       row_q;
  logic [COL_W-1:0]       col_q;
  logic signed [SH_W-1:0] shift_q;
  logic [SAT_W-1:0]       sat_q;
  logic [1:0]             log_n2_q;
  logic                   running_q;
  logic [COL_W-1:0]       col_last;
  logic                   end_row, end_col, end_shift, end_sat;
  logic [ROW_W-1:0]       rot;

  always_comb begin
    case (log_n2_q)
      2'd0:    col_last = 2'd0;
      2'd1:    col_last = 2'd1;
      default: col_last = 2'd3;
    endcase
  end

  assign end_row   = (row_q == ROW_W'(N1 - 1));
  assign end_col   = (col_q == col_last);
  assign end_shift = (shift_q == SH_W'(SHIFT_MAX));
  assign end_sat   = (sat_q == SAT_W'(NUM_SAT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      shift_q   <= '0;
      sat_q     <= '0;
      log_n2_q  <= '0;
    end else if (start_go_i) begin
      running_q <= 1'b1;
      row_q     <= '0;
      col_q     <= '0;
      shift_q   <= SH_W'(-SHIFT_MAX);
      sat_q     <= '0;
      log_n2_q  <= n2_log(n2_sel_i);
    end else if (running_q && adv_i) begin
      row_q <= row_q + 1'b1;
      if (end_row) begin
        row_q <= '0;
        col_q <= col_q + 1'b1;
        if (end_col) begin
          col_q   <= '0;
          shift_q <= shift_q + 1'b1;
          if (end_shift) begin
            shift_q <= SH_W'(-SHIFT_MAX);
            sat_q   <= sat_q + 1'b1;
            if (end_sat) running_q <= 1'b0;
          end
        end
      end
    end
  end

  // (row - s) mod N1 by power-of-two wrap
  assign rot        = row_q - ROW_W'(shift_q);
  assign fft_addr_o = (FFT_AW'(row_q) << log_n2_q) | FFT_AW'(col_q);
  assign rep_addr_o = {sat_q, rot};
  assign rd_en_o    = running_q & adv_i;
  assign running_o  = running_q;
  assign sat_o      = sat_q;
  assign shift_o    = shift_q;
  assign col_o      = col_q;
  assign first_o    = (row_q == '0);
  assign last_o     = end_row;

  AST_SHIFT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> (int'(shift_q) >= -SHIFT_MAX) && (int'(shift_q) <= SHIFT_MAX)); // R7
  AST_FFT_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (int'(fft_addr_o) < (N1 << log_n2_q))); // R4
endmodule

// File: rtl/fdc_cmul_conj.sv
`timescale 1ns/1ps
module fdc_cmul_conj #(
  parameter int W   = 16,
  localparam int PW = 2 * W,
  localparam int OW = 2 * W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [W-1:0]  a_re_i,
  input  logic signed [W-1:0]  a_im_i,
  input  logic signed [W-1:0]  b_re_i,
  input  logic signed [W-1:0]  b_im_i,
  output logic signed [OW-1:0] re_o,
  output logic signed [OW-1:0] im_o
);
  logic signed [PW-1:0] p_ac, p_bd, p_bc, p_ad;

  // stage 1: four partial products
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_ac <= '0;
      p_bd <= '0;
      p_bc <= '0;
      p_ad <= '0;
    end else if (en_i) begin
      p_ac <= a_re_i * b_re_i;
      p_bd <= a_im_i * b_im_i;
      p_bc <= a_im_i * b_re_i;
      p_ad <= a_re_i * b_im_i;
    end
  end

  // stage 2: conjugate combine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_o <= '0;
      im_o <= '0;
    end else if (en_i) begin
      re_o <= OW'(p_ac) + OW'(p_bd);
      im_o <= OW'(p_bc) - OW'(p_ad);
    end
  end
endmodule

// File: rtl/fdc_sweep_seq.sv
`timescale 1ns/1ps
module fdc_sweep_seq
  import fdc_pkg::*;
#(
  parameter int N1        = 2048,
  parameter int NUM_SAT   = 24,
  parameter int SHIFT_MAX = 10,
  parameter int W         = 16,
  localparam int ROW_W    = $clog2(N1),
  localparam int SAT_W    = $clog2(NUM_SAT),
  localparam int SH_W     = $clog2(SHIFT_MAX + 1) + 1,
  localparam int FFT_AW   = ROW_W + COL_W,
  localparam int REP_AW   = SAT_W + ROW_W,
  localparam int OW       = 2 * W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [1:0]              n2_sel_i,
  output logic                    busy_o,
  output logic                    mem_rd_o,
  output logic [FFT_AW-1:0]       fft_addr_o,
  input  logic signed [W-1:0]     fft_re_i,
  input  logic signed [W-1:0]     fft_im_i,
  output logic [REP_AW-1:0]       rep_addr_o,
  input  logic signed [W-1:0]     rep_re_i,
  input  logic signed [W-1:0]     rep_im_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic signed [OW-1:0]    out_re_o,
  output logic signed [OW-1:0]    out_im_o,
  output logic [SAT_W-1:0]        out_sat_o,
  output logic signed [SH_W-1:0]  out_shift_o,
  output logic [COL_W-1:0]        out_col_o,
  output logic                    out_first_o,
  output logic                    out_last_o
);
  localparam int NSTG = 3;  // memory, product, sum
  localparam int TAG_W = SAT_W + SH_W + COL_W + 2;

  logic             adv, running, start_go;
  logic [SAT_W-1:0] g_sat;
  logic signed [SH_W-1:0] g_shift;
  logic [COL_W-1:0] g_col;
  logic             g_first, g_last;
  logic [NSTG-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [NSTG];

  assign adv      = !vld_q[NSTG-1] || out_ready_i;
  assign busy_o   = running || (|vld_q);
  assign start_go = start_i && !busy_o;

  fdc_addr_gen #(
    .N1(N1), .NUM_SAT(NUM_SAT), .SHIFT_MAX(SHIFT_MAX)
  ) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_go_i (start_go),
    .n2_sel_i   (n2_sel_i),
    .adv_i      (adv),
    .running_o  (running),
    .rd_en_o    (mem_rd_o),
    .fft_addr_o (fft_addr_o),
    .rep_addr_o (rep_addr_o),
    .sat_o      (g_sat),
    .shift_o    (g_shift),
    .col_o      (g_col),
    .first_o    (g_first),
    .last_o     (g_last)
  );

  fdc_cmul_conj #(.W(W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adv),
    .a_re_i (fft_re_i),
    .a_im_i (fft_im_i),
    .b_re_i (rep_re_i),
    .b_im_i (rep_im_i),
    .re_o   (out_re_o),
    .im_o   (out_im_o)
  );

  // tag/valid pipeline aligned with memory latency and multiplier stages
  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[k] <= 1'b0;
        tag_q[k] <= '0;
      end else if (adv) begin
        if (k == 0) begin
          vld_q[k] <= running;
          tag_q[k] <= {g_sat, g_shift, g_col, g_first, g_last};
        end else begin
          vld_q[k] <= vld_q[k-1];
          tag_q[k] <= tag_q[k-1];
        end
      end
    end
  end

  assign out_valid_o = vld_q[NSTG-1];
  assign {out_sat_o, out_shift_o, out_col_o, out_first_o, out_last_o} = tag_q[NSTG-1];

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_re_o) && $stable(out_im_o)
      && $stable(out_sat_o) && $stable(out_shift_o) && $stable(out_col_o))); // R9
  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o); // R10
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_FIRST_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> (!out_valid_o || out_first_o)); // R8
endmodule

// File: tb/fdc_sweep_seq_test.sv
`timescale 1ns/1ps
module fdc_sweep_seq_test;
  localparam int N1 = 8;
  localparam int NSAT = 3;
  localparam int SMAX = 2;
  localparam int W = 8;
  localparam int ROW_W = $clog2(N1);
  localparam int SAT_W = $clog2(NSAT);
  localparam int SH_W = $clog2(SMAX + 1) + 1;
  localparam int FFT_AW = ROW_W + 2;
  localparam int REP_AW = SAT_W + ROW_W;
  localparam int OW = 2 * W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] n2_sel = 2'd0;
  logic out_ready = 1'b0;
  logic busy, mem_rd, out_valid, out_first, out_last;
  logic [FFT_AW-1:0] fft_addr;
  logic [REP_AW-1:0] rep_addr;
  logic signed [W-1:0] fft_re, fft_im, rep_re, rep_im;
  logic signed [OW-1:0] out_re, out_im;
  logic [SAT_W-1:0] out_sat;
  logic signed [SH_W-1:0] out_shift;
  logic [1:0] out_col;

  int checks = 0, failures = 0, seen = 0, ready_pct = 100;
  int e_sat, e_sh, e_col, e_row, e_ln2;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fdc_sweep_seq #(.N1(N1), .NUM_SAT(NSAT), .SHIFT_MAX(SMAX), .W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n2_sel_i(n2_sel),
    .busy_o(busy), .mem_rd_o(mem_rd),
    .fft_addr_o(fft_addr), .fft_re_i(fft_re), .fft_im_i(fft_im),
    .rep_addr_o(rep_addr), .rep_re_i(rep_re), .rep_im_i(rep_im),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_re_o(out_re), .out_im_o(out_im), .out_sat_o(out_sat),
    .out_shift_o(out_shift), .out_col_o(out_col),
    .out_first_o(out_first), .out_last_o(out_last)
  );

  function automatic int fre(int a); return ((a * 7 + 3) % 251) - 125; endfunction
  function automatic int fim(int a); return ((a * 13 + 11) % 241) - 120; endfunction
  function automatic int rre(int a); return ((a * 29 + 5) % 239) - 119; endfunction
  function automatic int rim(int a); return ((a * 17 + 1) % 233) - 116; endfunction

  // memory models: data follows address one cycle after a read enable
  always_ff @(posedge clk) begin
    if (mem_rd) begin
      fft_re <= W'(fre(int'(fft_addr)));
      fft_im <= W'(fim(int'(fft_addr)));
      rep_re <= W'(rre(int'(rep_addr)));
      rep_im <= W'(rim(int'(rep_addr)));
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: drive ready, then judge the element that the next edge takes
  initial begin
    bit hold = 0;
    int h_re = 0, h_im = 0, h_tag = 0;
    forever begin
      @(negedge clk);
      if (hold) begin
        check(out_valid && int'(out_re) == h_re && int'(out_im) == h_im &&
              int'({out_sat, out_shift, out_col}) == h_tag,
              "R9 hold", int'(out_re), h_re);
      end
      out_ready = (($urandom % 100) < ready_pct);
      if (out_valid && out_ready) begin
        int fa, ra, a, b, c, d;
        fa = (e_row << e_ln2) | e_col;                                 // R4
        ra = e_sat * N1 + (((e_row - e_sh) % N1) + N1) % N1;           // R5
        a = fre(fa); b = fim(fa); c = rre(ra); d = rim(ra);
        check(int'(out_re) == a * c + b * d && int'(out_im) == b * c - a * d,
              "R6 product", int'(out_re), a * c + b * d);
        check(int'(out_sat) == e_sat && int'(out_shift) == e_sh && int'(out_col) == e_col,
              "R7 tags", int'(out_sat) * 100 + int'(out_shift) * 10 + int'(out_col),
              e_sat * 100 + e_sh * 10 + e_col);
        check(out_first == (e_row == 0) && out_last == (e_row == N1 - 1),
              "R8 flags", int'({out_first, out_last}),
              int'({(e_row == 0), (e_row == N1 - 1)}));
        seen++;
        e_row++;
        if (e_row == N1) begin
          e_row = 0; e_col++;
          if (e_col == (1 << e_ln2)) begin
            e_col = 0; e_sh++;
            if (e_sh > SMAX) begin e_sh = -SMAX; e_sat++; end
          end
        end
      end
      hold = out_valid && !out_ready;
      h_re = int'(out_re); h_im = int'(out_im);
      h_tag = int'({out_sat, out_shift, out_col});
    end
  end

  task automatic sweep(input logic [1:0] sel, input int pct, input bit disturb);
    int ln2, total;
    ln2 = (sel == 2'd0) ? 0 : (sel == 2'd1) ? 1 : 2;     // R3
    total = NSAT * (2 * SMAX + 1) * (1 << ln2) * N1;
    e_sat = 0; e_sh = -SMAX; e_col = 0; e_row = 0; e_ln2 = ln2;
    seen = 0; ready_pct = pct;
    @(negedge clk);
    n2_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    if (disturb) begin
      repeat (40) @(negedge clk);
      start = 1'b1; n2_sel = (sel == 2'd0) ? 2'd2 : 2'd0;   // R2 R3 ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    check(seen == total, "R2 R3 element count", seen, total);
    check(!mem_rd && !out_valid, "R10 idle after sweep", int'({mem_rd, out_valid}), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy && !mem_rd && !out_valid, "R1 reset state",
          int'({busy, mem_rd, out_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !out_valid, "R1 after release", int'({busy, out_valid}), 0);
    sweep(2'd2, 50, 1'b1);
    sweep(2'd0, 100, 1'b0);
    sweep(2'd1, 75, 1'b1);
    sweep(2'd3, 60, 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule